// File: doc/BRIEF.md
# Switched-Capacitor DAC Update Sequencer

This block is the digital control front end of a switched-capacitor voltage DAC. It accepts a 13-bit code on a valid/ready write port. A format input selects how the code is read: two's complement (format 0) or sign-and-magnitude (format 1). The block converts every accepted code to sign-and-magnitude and holds it as a pending value. It copies the pending value into a current value on a four-phase refresh cycle. That copy happens either on every cycle (continuous mode) or only after a qualified strobe (strobe mode). The converted current value then drives the capacitor switch controls.

A one-cycle `sc_tick` from the switched-capacitor clock advances the refresh phase. The phase enables come out one-hot. The copy from pending to current takes place on entry to the new-value phase, and the interrupt pulses when it does. The sign and magnitude outputs are refreshed on entry to the buffer-output phase. A separate output tells the output buffer to go high impedance.

Write port rules for back-pressure: a code is taken on any clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` stays low for the whole new-value phase. A producer keeps `wr_valid` high and `wr_code` steady until the code is taken.

Top module: `scdac_seq`

## Requirements
- R1: With `fmt_sm`=0, the written code is two's complement. A negative code gives sign 1 and magnitude equal to its absolute value. A non-negative code gives sign 0 and magnitude equal to the code.
- R2: With `fmt_sm`=1, bit 12 is the sign and bits 11:0 are the magnitude. A code with magnitude 0 and sign 1 is output as sign 0, magnitude 0. More generally, `dac_mag`=0 always comes with `dac_sign`=0.
- R3: The two's-complement code 13'h1000 (-4096) saturates to sign 1, magnitude 4095.
- R4: `ph_en` is one-hot, and each `sc_tick` moves it one bit higher, wrapping from bit 3 to bit 0. Bit 0 is the new-value phase and bit 2 is the buffer-output phase. After reset the block is in phase 3.
- R5: In continuous mode (`strobe_mode`=0), the pending value is loaded into the current value on every entry to phase 0. `dac_sign` and `dac_mag` change only on entry to phase 2, when they take the current value.
- R6: In strobe mode, the current value does not change unless a strobe has been qualified. A strobe is qualified when `strobe_in` stays high for at least STB_MIN_CYC (default 2) consecutive synchronised clock cycles. A shorter pulse is ignored.
- R7: `irq` is high for exactly one cycle after each load of the current value, and it is low otherwise.
- R8: `wr_ready` is low throughout phase 0 and high in phases 1 to 3.
- R9: `out_hiz` is 1 after reset. One clock after `drive_en` changes, `out_hiz` equals the inverse of `drive_en`.
- R10: Several qualified strobes that arrive before the same phase-0 entry produce a single load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_tick | input | 1 | One-cycle pulse per switched-capacitor clock edge |
| fmt_sm | input | 1 | Code format: 0 two's complement, 1 sign-and-magnitude |
| strobe_mode | input | 1 | 0 continuous update, 1 strobe-gated update |
| strobe_in | input | 1 | Asynchronous update strobe |
| drive_en | input | 1 | 1 drives the output buffer, 0 requests high impedance |
| wr_valid | input | 1 | Write code valid |
| wr_ready | output | 1 | Write code accepted when high with valid |
| wr_code | input | 13 | Written code |
| ph_en | output | 4 | One-hot refresh phase enables |
| dac_sign | output | 1 | Sign to capacitor switch control |
| dac_mag | output | 12 | Magnitude to capacitor switch control |
| out_hiz | output | 1 | Output buffer high-impedance control |
| irq | output | 1 | Pulse when pending becomes current |

## Verification
Two events can land on the same clock edge: a write being accepted into the pending register and the load into the current register at phase-0 entry. The bench provokes this by raising `wr_valid` together with `sc_tick` while phase 3 is active. It judges the result by three observations. The next buffer-output phase must still show the old code. `irq` must pulse once. The new code must appear only after the following refresh. Strobe qualification is also exercised around a refresh boundary. The bench checks that a short pulse is dropped and that merged strobes give exactly one interrupt.

// File: rtl/scdac_pkg.sv
package scdac_pkg;
  localparam int CODE_W = 13;
  localparam int MAG_W  = CODE_W - 1;
  localparam int NPH    = 4;

  typedef enum logic [1:0] {
    PH_NEWVAL = 2'd0,
    PH_SETTLE = 2'd1,
    PH_BUFOUT = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
  } sm_t;
endpackage

// File: rtl/scdac_fmt_conv.sv
module scdac_fmt_conv
  import scdac_pkg::*;
(
  input  logic              fmt_sm,
  input  logic [CODE_W-1:0] code,
  output sm_t               sm
);
  localparam logic [CODE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};
  logic [CODE_W-1:0] negated;

  always_comb begin
    negated = ~code + 1'b1;
    if (fmt_sm) begin
      // negative zero folds onto zero
      sm.sign = code[CODE_W-1] & (|code[MAG_W-1:0]);
      sm.mag  = code[MAG_W-1:0];
    end else if (code[CODE_W-1]) begin
      sm.sign = 1'b1;
      sm.mag  = (code == MOST_NEG) ? {MAG_W{1'b1}} : negated[MAG_W-1:0];
    end else begin
      sm.sign = 1'b0;
      sm.mag  = code[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/scdac_phase_gen.sv
module scdac_phase_gen
  import scdac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  output logic [NPH-1:0] ph_en,
  output logic           nv_start,
  output logic           bo_start,
  output logic           in_newval
);
  phase_e ph;

  always_ff @(posedge clk) begin
    if (!rst_n)    ph <= PH_HOLD;
    else if (tick) ph <= phase_e'(ph + 2'd1);
  end

  for (genvar i = 0; i < NPH; i++) begin : g_en
    assign ph_en[i] = (ph == phase_e'(i));
  end

  assign nv_start  = tick && (ph == PH_HOLD);
  assign bo_start  = tick && (ph == PH_SETTLE);
  assign in_newval = (ph == PH_NEWVAL);
endmodule

// File: rtl/scdac_strobe_qual.sv
module scdac_strobe_qual #(
  parameter int MIN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic qual
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= strobe_async;
      s2 <= s1;
      if (!s2)             cnt <= '0;
      else if (cnt != SAT) cnt <= cnt + 1'b1;
    end
  end

  // fires once per pulse, on its MIN_CYC-th high cycle
  assign qual = s2 && (cnt == LAST);
endmodule

// File: rtl/scdac_seq.sv
module scdac_seq
  import scdac_pkg::*;
#(
  parameter int STB_MIN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sc_tick,
  input  logic              fmt_sm,
  input  logic              strobe_mode,
  input  logic              strobe_in,
  input  logic              drive_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CODE_W-1:0] wr_code,
  output logic [NPH-1:0]    ph_en,
  output logic              dac_sign,
  output logic [MAG_W-1:0]  dac_mag,
  output logic              out_hiz,
  output logic              irq
);
  logic nv_start, bo_start, in_newval, stb_qual, armed, load;
  sm_t  conv, pend, cur;

  scdac_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .tick(sc_tick), .ph_en(ph_en),
    .nv_start(nv_start), .bo_start(bo_start), .in_newval(in_newval)
  );

  scdac_fmt_conv u_conv (.fmt_sm(fmt_sm), .code(wr_code), .sm(conv));

  scdac_strobe_qual #(.MIN_CYC(STB_MIN_CYC)) u_stb (
    .clk(clk), .rst_n(rst_n), .strobe_async(strobe_in), .qual(stb_qual)
  );

  assign wr_ready = !in_newval;
  assign load     = nv_start && (!strobe_mode || armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      cur     <= '0;
      dac_sign <= 1'b0;
      dac_mag <= '0;
      armed   <= 1'b0;
      irq     <= 1'b0;
      out_hiz <= 1'b1;
    end else begin
      if (wr_valid && wr_ready) pend <= conv;
      if (load)                 cur  <= pend;
      if (bo_start) begin
        dac_sign <= cur.sign;
        dac_mag  <= cur.mag;
      end
      if (!strobe_mode) armed <= 1'b0;
      else              armed <= (armed && !nv_start) || stb_qual;
      irq     <= load;
      out_hiz <= !drive_en;
    end
  end
endmodule

// File: rtl/scdac_seq_chk.sv
module scdac_seq_chk #(
  parameter int MAG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sc_tick,
  input logic [3:0]       ph_en,
  input logic             wr_ready,
  input logic             drive_en,
  input logic             out_hiz,
  input logic             irq,
  input logic             dac_sign,
  input logic [MAG_W-1:0] dac_mag
);
  p_phase_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ph_en) == 1);

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_tick && ph_en[3]) |=> ph_en[0]);

  p_ready_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_en[0] |-> !wr_ready);

  p_out_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_tick && ph_en[1]) |=> ($stable(dac_mag) && $stable(dac_sign)));

  p_zero_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_mag == '0) |-> !dac_sign);

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_hiz_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drive_en) |-> !out_hiz);
endmodule

bind scdac_seq scdac_seq_chk #(.MAG_W(scdac_pkg::MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sc_tick(sc_tick), .ph_en(ph_en),
  .wr_ready(wr_ready), .drive_en(drive_en), .out_hiz(out_hiz), .irq(irq),
  .dac_sign(dac_sign), .dac_mag(dac_mag)
);

// File: tb/sim_scdac_seq.sv
module sim_scdac_seq;
  localparam int CLK_P = 10;
  localparam int NV = 9;
  // {fmt_sm, code[12:0], exp_sign, exp_mag[11:0]}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 13'h0000, 1'b0, 12'd0},
    {1'b0, 13'h0005, 1'b0, 12'd5},
    {1'b0, 13'h1FFF, 1'b1, 12'd1},
    {1'b0, 13'h1000, 1'b1, 12'd4095},
    {1'b0, 13'h0FFF, 1'b0, 12'd4095},
    {1'b0, 13'h1F9C, 1'b1, 12'd100},
    {1'b1, 13'h1005, 1'b1, 12'd5},
    {1'b1, 13'h1000, 1'b0, 12'd0},
    {1'b1, 13'h0ABC, 1'b0, 12'hABC}
  };

  logic clk = 0, rst_n = 0, sc_tick = 0, fmt_sm = 0, strobe_mode = 0;
  logic strobe_in = 0, drive_en = 0, wr_valid = 0;
  logic [12:0] wr_code = '0;
  logic wr_ready, dac_sign, out_hiz, irq;
  logic [3:0] ph_en;
  logic [11:0] dac_mag;
  int checks = 0, errors = 0, irq_cnt;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  scdac_seq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) sc_tick = 1;
    @(negedge clk) sc_tick = 0;
  endtask

  task automatic refresh();
    irq_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (irq) irq_cnt++;
    end
  endtask

  task automatic write(input logic [12:0] c);
    @(negedge clk) begin wr_valid = 1; wr_code = c; end
    @(negedge clk) wr_valid = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk) strobe_in = 1;
    repeat (n) @(negedge clk);
    strobe_in = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset hiz", out_hiz, 1);
    chk("R4 reset phase", ph_en, 4'b1000);
    chk("R7 reset irq", irq, 0);
    chk("R8 reset ready", wr_ready, 1);

    // R1 R2 R3 R5 R7: vector walk in continuous mode
    for (int i = 0; i < NV; i++) begin
      fmt_sm = VEC[i][26];
      write(VEC[i][25:13]);
      refresh();
      chk($sformatf("R1/R2/R3 sign v%0d", i), dac_sign, VEC[i][12]);
      chk($sformatf("R1/R2/R3 mag v%0d", i), dac_mag, VEC[i][11:0]);
      chk($sformatf("R7 irq count v%0d", i), irq_cnt, 1);
    end
    fmt_sm = 0;

    // R4 R8: phase sequence and write hold-off
    tick();
    chk("R4 phase0", ph_en, 4'b0001);
    chk("R8 ready low in phase0", wr_ready, 0);
    tick();
    chk("R4 phase1", ph_en, 4'b0010);
    chk("R8 ready high in phase1", wr_ready, 1);
    tick();
    chk("R4 phase2", ph_en, 4'b0100);
    tick();
    chk("R4 phase3", ph_en, 4'b1000);

    // R5 collision: write accepted on the load edge
    @(negedge clk) begin wr_valid = 1; wr_code = 13'd7; sc_tick = 1; end
    @(negedge clk) begin wr_valid = 0; sc_tick = 0; end
    chk("R7 irq on collision load", irq, 1);
    tick(); tick(); tick();
    chk("R5 collision keeps old code", dac_mag, 12'hABC);
    refresh();
    chk("R5 new code next refresh", dac_mag, 7);

    // R6 strobe mode
    strobe_mode = 1;
    write(13'd9);
    refresh();
    chk("R6 no strobe no load", dac_mag, 7);
    chk("R6 no strobe no irq", irq_cnt, 0);
    pulse(1);
    refresh();
    chk("R6 short strobe ignored", dac_mag, 7);
    chk("R6 short strobe no irq", irq_cnt, 0);
    pulse(3);
    refresh();
    chk("R6 valid strobe loads", dac_mag, 9);
    chk("R7 strobe irq", irq_cnt, 1);

    // R10 merged strobes
    write(13'd11);
    pulse(3);
    pulse(3);
    refresh();
    chk("R10 merged load value", dac_mag, 11);
    chk("R10 single irq", irq_cnt, 1);
    refresh();
    chk("R10 no second load", irq_cnt, 0);
    strobe_mode = 0;

    // R9 hi-z control
    @(negedge clk) drive_en = 1;
    @(negedge clk) chk("R9 driven", out_hiz, 0);
    drive_en = 0;
    @(negedge clk) chk("R9 back to hiz", out_hiz, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule